// File: doc/BRIEF.md
# Adder-Subtracter with Compare Flags

A purely combinational arithmetic slice for N-bit two's complement operands. A single ripple-carry chain of full adders produces either A+B or A-B, selected by a one-bit mode input. Subtraction does not use a second adder. Each bit of B is inverted, and a two-way selector chooses between the raw B and the inverted B. The "+1" that completes the negation enters the chain as its carry-in.

The same result word drives a small flag unit. The less flag is the top bit of the result. The equal flag is a NOR across every result bit. The greater flag is set when neither of the other two is. A not-equal output is also provided.

With the mode at subtract, the flags give a three-way compare of A against B. No correction is made for signed overflow, so the compare is only exact when A-B fits in N bits. With the mode at add, the flags report the sign and zero state of the sum. The carry out of the top stage is exported.

Top module: `addsub_cmp`

## Requirements
- R1: With mode_i = 0 (add), {carry_o, sum_o} equals the (N+1)-bit unsigned sum A + B.
- R2: With mode_i = 1 (subtract), sum_o equals A + (bitwise inverse of B) + 1 modulo 2^N, that is A - B. The +1 comes from the adder carry-in.
- R3: carry_o is the carry out of the most significant full adder. In subtract mode it is 1 exactly when A >= B as unsigned numbers; for example 0 - 0 gives 1.
- R4: lt_o equals bit N-1 (the sign bit) of sum_o.
- R5: eq_o is 1 exactly when every bit of sum_o is 0. In subtract mode this means A == B.
- R6: gt_o is 1 exactly when both lt_o and eq_o are 0.
- R7: ne_o is always the inverse of eq_o.
- R8: For every input combination, exactly one of lt_o, eq_o and gt_o is 1.
- R9: In add mode the flags follow the sum, with no special case. For example, 0xFF + 0x01 at N=8 gives sum 0x00, eq_o = 1 and carry_o = 1. Likewise 0x7F + 0x01 gives 0x80 with lt_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Operand A, two's complement |
| b_i | input | N | Operand B, two's complement |
| mode_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | N | A+B or A-B |
| carry_o | output | 1 | Carry out of the top adder stage |
| lt_o | output | 1 | Result sign bit (A < B in subtract mode) |
| eq_o | output | 1 | Result is zero |
| gt_o | output | 1 | Result is neither negative nor zero |
| ne_o | output | 1 | Inverse of eq_o |

## Verification
Every output is a combinational function of the current a_i, b_i and mode_i. Each result is therefore due in the same cycle as the stimulus, with zero register stages. The driver changes the inputs just after a rising edge and pushes the expected item into the queue. The monitor pops that item and compares it at the following falling edge, half a period later. Each queue entry is consumed in the cycle it was produced, so no result is ever compared against a neighbouring stimulus.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/addsub_bsel.sv
// Complement path: per-bit inverter followed by a 2:1 selector
module addsub_bsel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_o
);
  logic [W-1:0] b_inv;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign b_inv[k] = ~b_i[k];
    assign b_o[k]   = sub_i ? b_inv[k] : b_i[k];
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_fa
    logic p;
    assign p          = a_i[k] ^ b_i[k];
    assign sum_o[k]   = p ^ c[k];
    assign c[k+1]     = (a_i[k] & b_i[k]) | (p & c[k]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o,
  output logic         ne_o
);
  localparam int unsigned MSB = W - 1;

  assign lt_o = res_i[MSB];
  assign eq_o = ~(|res_i);   // zero tester
  assign gt_o = ~lt_o & ~eq_o;
  assign ne_o = ~eq_o;
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
  import addsub_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         mode_i,
  output logic [N-1:0] sum_o,
  output logic         carry_o,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o,
  output logic         ne_o
);
  op_e          op;
  logic         sub;
  logic [N-1:0] b_sel;

  assign op  = op_e'(mode_i);
  assign sub = (op == OP_SUB);

  addsub_bsel #(.W(N)) u_bsel (
    .b_i  (b_i),
    .sub_i(sub),
    .b_o  (b_sel)
  );

  // +1 of the negation enters as carry-in
  addsub_ripple #(.W(N)) u_add (
    .a_i   (a_i),
    .b_i   (b_sel),
    .cin_i (sub),
    .sum_o (sum_o),
    .cout_o(carry_o)
  );

  addsub_flags #(.W(N)) u_flags (
    .res_i(sum_o),
    .lt_o (lt_o),
    .eq_o (eq_o),
    .gt_o (gt_o),
    .ne_o (ne_o)
  );
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
  parameter int unsigned N = 8
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         mode_i,
  input logic [N-1:0] sum_o,
  input logic         carry_o,
  input logic         lt_o,
  input logic         eq_o,
  input logic         gt_o
);
  logic [N:0]   add_ref;
  logic [N-1:0] sub_ref;

  assign add_ref = {1'b0, a_i} + {1'b0, b_i};
  assign sub_ref = a_i - b_i;

  always_comb begin
    if (!mode_i) begin
      AST_ADD_SUM: assert ({carry_o, sum_o} == add_ref) else $error("add result"); // R1
    end else begin
      AST_SUB_DIFF: assert (sum_o == sub_ref) else $error("sub result");           // R2
      AST_SUB_CARRY: assert (carry_o == (a_i >= b_i)) else $error("sub carry");    // R3
      AST_SUB_EQUAL: assert (eq_o == (a_i == b_i)) else $error("sub equal");       // R5
    end
    AST_ONE_FLAG: assert ($onehot({lt_o, eq_o, gt_o})) else $error("flags");       // R8
  end
endmodule

bind addsub_cmp addsub_cmp_chk #(.N(N)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .mode_i (mode_i),
  .sum_o  (sum_o),
  .carry_o(carry_o),
  .lt_o   (lt_o),
  .eq_o   (eq_o),
  .gt_o   (gt_o)
);

// File: tb/tb_addsub_cmp.sv
`timescale 1ns/1ps
module tb_addsub_cmp;
  localparam time TCLK = 8ns;

  typedef struct {
    logic       w4;
    logic       mode;
    logic [7:0] sum;
    logic       c, lt, eq, gt, ne;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic [7:0] a8 = '0, b8 = '0;
  logic       m8 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       m4 = 1'b0;

  logic [7:0] s8;
  logic       c8, lt8, eq8, gt8, ne8;
  logic [3:0] s4;
  logic       c4, lt4, eq4, gt4, ne4;

  addsub_cmp #(.N(8)) dut (
    .a_i(a8), .b_i(b8), .mode_i(m8), .sum_o(s8), .carry_o(c8),
    .lt_o(lt8), .eq_o(eq8), .gt_o(gt8), .ne_o(ne8)
  );

  addsub_cmp #(.N(4)) dut4 (
    .a_i(a4), .b_i(b4), .mode_i(m4), .sum_o(s4), .carry_o(c4),
    .lt_o(lt4), .eq_o(eq4), .gt_o(gt4), .ne_o(ne4)
  );

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int n_vec = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference from the requirements
  function automatic exp_t model(input logic w4, input logic [7:0] a, input logic [7:0] b,
                                 input logic m);
    exp_t e;
    logic [7:0] mask, bb;
    logic [8:0] full;
    int w;
    w    = w4 ? 4 : 8;
    mask = w4 ? 8'h0F : 8'hFF;
    bb   = m ? (~b & mask) : (b & mask);
    full = {1'b0, a & mask} + {1'b0, bb} + {8'd0, m};
    e.w4   = w4;
    e.mode = m;
    e.sum  = full[7:0] & mask;
    e.c    = full[w];
    e.lt   = e.sum[w-1];
    e.eq   = (e.sum == 8'd0);
    e.gt   = !e.lt && !e.eq;
    e.ne   = !e.eq;
    return e;
  endfunction

  task automatic drive(input logic w4, input logic [7:0] a, input logic [7:0] b, input logic m);
    @(posedge clk);
    #1;
    if (w4) begin
      a4 = a[3:0]; b4 = b[3:0]; m4 = m;
    end else begin
      a8 = a; b8 = b; m8 = m;
    end
    exp_q.push_back(model(w4, a, b, m));
    n_vec++;
  endtask

  // monitor: results are combinational, due in the same cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] s;
      logic c, lt, eq, gt, ne;
      e = exp_q.pop_front();
      if (e.w4) begin
        s = {4'd0, s4}; c = c4; lt = lt4; eq = eq4; gt = gt4; ne = ne4;
      end else begin
        s = s8; c = c8; lt = lt8; eq = eq8; gt = gt8; ne = ne8;
      end
      check(e.mode ? "R2" : "R1", "sum", int'(s), int'(e.sum));
      check("R3", "carry", int'(c), int'(e.c));
      check(e.mode ? "R4" : "R4/R9", "lt", int'(lt), int'(e.lt));
      check(e.mode ? "R5" : "R5/R9", "eq", int'(eq), int'(e.eq));
      check("R6", "gt", int'(gt), int'(e.gt));
      check("R7", "ne", int'(ne), int'(e.ne));
      check("R8", "one-hot count", int'(lt) + int'(eq) + int'(gt), 1);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle-state vector: all zero inputs give a zero result, equal set (R5)
    drive(1'b0, 8'h00, 8'h00, 1'b0);
    // R3: 0 - 0 carries out; R5 equal
    drive(1'b0, 8'h00, 8'h00, 1'b1);
    // R4 less: 5 - 9
    drive(1'b0, 8'h05, 8'h09, 1'b1);
    // R6 greater: 9 - 5
    drive(1'b0, 8'h09, 8'h05, 1'b1);
    // R9: add wrap to zero with carry, and into the sign bit
    drive(1'b0, 8'hFF, 8'h01, 1'b0);
    drive(1'b0, 8'h7F, 8'h01, 1'b0);
    // R4: overflowing difference keeps the raw sign bit
    drive(1'b0, 8'h80, 8'h01, 1'b1);
    drive(1'b0, 8'hFF, 8'hFF, 1'b1);
    // exhaustive at N=4, both modes (R1..R8)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(1'b1, 8'(a), 8'(b), 1'(m));
    // random at N=8
    for (int i = 0; i < 2000; i++)
      drive(1'b0, 8'($urandom), 8'($urandom), 1'($urandom));
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule